// File: doc/BRIEF.md
# PTP pin waveform generator

This block drives a single output pin from a local time-of-day counter. The counter holds a seconds field and a nanoseconds field, and it advances by a fixed nanosecond step on every clock. The pin has two modes. In second-aligned mode it produces a pulse at a set delay after each seconds rollover. In free-running mode it produces a periodic clock whose high and low times are set independently.

Software uses a small register write port to load three values: a high-period register, a low-period register and a configuration word. The two period registers mean different things in each mode. In second-aligned mode the low register is the delay after the rollover and the high register is the pulse width. In free-running mode the two registers are the high and low halves of the clock.

Writing the two period registers only stages them. The staged values are checked when the configuration word is written. An accepted configuration waits for the next period boundary before it drives the pin, so no runt pulse appears. A rejected configuration leaves the running waveform untouched and sets a sticky error flag.

Top module: `ptp_pin_wavegen`

## Requirements
- R1: While reset is high, and right after it, the pin is low, the error flag is clear and both time-of-day fields read zero.
- R2: The nanoseconds field grows by NS_STEP on each clock. When the sum reaches SEC_NS, the field drops by SEC_NS (so it reads 0 when the step divides SEC_NS) and the seconds field increments by one.
- R3: The write port decodes three addresses: 0 is the high-period register, 1 is the low-period register, 2 is the configuration word. In the configuration word, bits [1:0] are the action (1 = clock output, 0 = off, 2 and 3 reserved), bit 2 selects second-aligned mode and bit 3 is disable. Writing a period register alone leaves the pin waveform unchanged.
- R4: In free-running mode the pin is high for high/NS_STEP clocks, then low for low/NS_STEP clocks, and this repeats. Starting from idle, the first high phase begins a few clocks after the configuration write.
- R5: A free-running configuration is accepted only if each period is greater than MIN_PER (6) and at most MAX_PER (0x3FFFFFFF). Otherwise it is rejected.
- R6: In second-aligned mode the pin is high exactly while the nanoseconds field lies in [low, low + high). The low register is the delay after the rollover and the high register is the pulse width.
- R7: In second-aligned mode a pulse that would run past the end of the second is cut off at the seconds rollover.
- R8: A second-aligned configuration is rejected when the delay is not below SEC_NS or when the width is zero. A configuration word with a reserved action is also rejected.
- R9: After reset the high-period register holds DEF_WIDTH (1000 ns) and the low-period register holds 0. Enabling second-aligned mode without writing them gives a 1000 ns pulse at each rollover.
- R10: A rejected configuration sets the error flag, which stays set until reset, and the previously active waveform keeps running unchanged.
- R11: An accepted configuration takes effect only at a boundary. For free-running mode the boundary is the end of the current low phase, or immediately when idle. For second-aligned mode it is the next seconds rollover.
- R12: A configuration word with the disable bit or action 0 drives the pin low on the second clock after the write and keeps it low. Any waiting configuration is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 high, 1 low, 2 configuration) |
| wr_data | input | 32 | Register write data |
| pin_out | output | 1 | Generated waveform, registered |
| cfg_err | output | 1 | Sticky flag for rejected configurations |
| tod_sec | output | SEC_W | Time-of-day seconds field |
| tod_ns | output | TOD_NS_W | Time-of-day nanoseconds field |

## Verification
The bench builds the block with NS_STEP = 4 and SEC_NS = 2000, so one second lasts 500 clocks. At that scale several seconds rollovers fit in a short run, which allows second-aligned pulses, rollover clipping and rollover-gated activation to be compared against the time-of-day outputs sample by sample. DEF_WIDTH keeps its default of 1000, which is half of the shortened second, so the reset-default pulse is also observable. Free-running periods are chosen as multiples of the step, so each phase length is an exact clock count.

// File: rtl/ptpw_pkg.sv
package ptpw_pkg;

  localparam int PER_DW = 32;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_HIGH = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd2;

  localparam logic [1:0] ACT_NONE  = 2'd0;
  localparam logic [1:0] ACT_CLOCK = 2'd1;

  localparam int CFG_SYNC_BIT = 2;
  localparam int CFG_DIS_BIT  = 3;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_FREE = 2'd1,
    MODE_SYNC = 2'd2
  } wave_mode_e;

  typedef struct packed {
    wave_mode_e         mode;
    logic [PER_DW-1:0]  high;
    logic [PER_DW-1:0]  low;
  } wave_cfg_t;

endpackage

// File: rtl/ptpw_tod.sv
module ptpw_tod #(
  parameter int NS_STEP  = 8,
  parameter int SEC_NS   = 1000000000,
  parameter int TOD_NS_W = 30,
  parameter int SEC_W    = 48
) (
  input  logic                clk,
  input  logic                rst,
  output logic [TOD_NS_W-1:0] ns_q,
  output logic [SEC_W-1:0]    sec_q,
  output logic [TOD_NS_W-1:0] ns_nxt,
  output logic                wrap
);

  localparam logic [TOD_NS_W:0] STEP_L = (TOD_NS_W+1)'(NS_STEP);
  localparam logic [TOD_NS_W:0] SEC_L  = (TOD_NS_W+1)'(SEC_NS);

  logic [TOD_NS_W:0] sum;
  logic [TOD_NS_W:0] folded;

  always_comb begin
    sum    = {1'b0, ns_q} + STEP_L;
    wrap   = (sum >= SEC_L);
    folded = wrap ? (sum - SEC_L) : sum;
    ns_nxt = folded[TOD_NS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q <= ns_nxt;
      if (wrap) sec_q <= sec_q + SEC_W'(1);
    end
  end

  // R2
  ns_range_chk: assert property (@(posedge clk) disable iff (rst)
    {1'b0, ns_q} < SEC_L);

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (sec_q == $past(sec_q) + SEC_W'(1)));

endmodule

// File: rtl/ptpw_cfg.sv
module ptpw_cfg
  import ptpw_pkg::*;
#(
  parameter int SEC_NS    = 1000000000,
  parameter int MIN_PER   = 6,
  parameter int MAX_PER   = 32'h3FFFFFFF,
  parameter int DEF_WIDTH = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [PER_DW-1:0] wr_data,
  output logic              commit_q,
  output wave_cfg_t         cmd_q,
  output logic              stop_q,
  output logic              err_q
);

  localparam logic [PER_DW-1:0] MIN_L = PER_DW'(MIN_PER);
  localparam logic [PER_DW-1:0] MAX_L = PER_DW'(MAX_PER);
  localparam logic [PER_DW-1:0] SEC_L = PER_DW'(SEC_NS);
  localparam logic [PER_DW-1:0] DEF_L = PER_DW'(DEF_WIDTH);

  logic [PER_DW-1:0] hi_q, lo_q;
  logic cfg_wr, sync_sel, want_stop, want_run, run_ok, reject;
  logic [1:0] act;

  function automatic logic free_ok(input logic [PER_DW-1:0] v);
    return (v > MIN_L) && (v <= MAX_L);
  endfunction

  always_comb begin
    cfg_wr    = wr_en && (wr_addr == ADDR_CFG);
    act       = wr_data[1:0];
    sync_sel  = wr_data[CFG_SYNC_BIT];
    want_stop = cfg_wr && (wr_data[CFG_DIS_BIT] || (act == ACT_NONE));
    want_run  = cfg_wr && !wr_data[CFG_DIS_BIT] && (act == ACT_CLOCK);
    run_ok    = sync_sel ? ((lo_q < SEC_L) && (hi_q != '0))
                         : (free_ok(hi_q) && free_ok(lo_q));
    reject    = cfg_wr && !want_stop && !(want_run && run_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= DEF_L;
      lo_q     <= '0;
      commit_q <= 1'b0;
      stop_q   <= 1'b0;
      err_q    <= 1'b0;
      cmd_q    <= '{mode: MODE_IDLE, high: '0, low: '0};
    end else begin
      commit_q <= want_run && run_ok;
      stop_q   <= want_stop;
      if (reject) err_q <= 1'b1;
      if (want_run && run_ok) begin
        cmd_q.mode <= sync_sel ? MODE_SYNC : MODE_FREE;
        cmd_q.high <= hi_q;
        cmd_q.low  <= lo_q;
      end
      if (wr_en && (wr_addr == ADDR_HIGH)) hi_q <= wr_data;
      if (wr_en && (wr_addr == ADDR_LOW))  lo_q <= wr_data;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R5
  free_range_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_q && (cmd_q.mode == MODE_FREE)) |->
      ((cmd_q.high > MIN_L) && (cmd_q.low <= MAX_L) && (cmd_q.low > MIN_L)));

  // R8
  sync_range_chk: assert property (@(posedge clk) disable iff (rst)
    (commit_q && (cmd_q.mode == MODE_SYNC)) |-> (cmd_q.low < SEC_L));

endmodule

// File: rtl/ptpw_engine.sv
module ptpw_engine
  import ptpw_pkg::*;
#(
  parameter int NS_STEP  = 8,
  parameter int TOD_NS_W = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  wave_cfg_t           cmd,
  input  logic                stop,
  input  logic [TOD_NS_W-1:0] tod_ns_nxt,
  input  logic                tod_wrap,
  output logic                pin_q
);

  localparam logic [PER_DW:0] STEP_L = (PER_DW+1)'(NS_STEP);
  localparam int PAD_W = PER_DW + 1 - TOD_NS_W;

  wave_cfg_t act_q, act_n, pend_q, pend_n;
  logic pend_vld_q, pend_vld_n;
  logic ph_low_q, ph_low_n;
  logic [PER_DW-1:0] el_q, el_n;
  logic [PER_DW:0] el_sum, el_rem;
  logic pin_n, end_low, apply;

  function automatic logic in_win(input logic [TOD_NS_W-1:0] ns,
                                  input logic [PER_DW-1:0] start,
                                  input logic [PER_DW-1:0] width);
    logic [PER_DW:0] ns_w;
    logic [PER_DW:0] diff;
    ns_w = {{PAD_W{1'b0}}, ns};
    diff = ns_w - {1'b0, start};
    return (ns_w >= {1'b0, start}) && (diff < {1'b0, width});
  endfunction

  always_comb begin
    act_n      = act_q;
    pend_n     = pend_q;
    pend_vld_n = pend_vld_q;
    ph_low_n   = ph_low_q;
    el_n       = el_q;
    pin_n      = 1'b0;
    el_rem     = '0;
    el_sum     = {1'b0, el_q} + STEP_L;
    end_low    = (act_q.mode == MODE_FREE) && ph_low_q &&
                 (el_sum >= {1'b0, act_q.low});
    if (pend_q.mode == MODE_SYNC)
      apply = pend_vld_q && tod_wrap;
    else
      apply = pend_vld_q && ((act_q.mode == MODE_IDLE) ||
                             ((act_q.mode == MODE_SYNC) && tod_wrap) ||
                             end_low);
    if (apply) begin
      act_n      = pend_q;
      pend_vld_n = 1'b0;
      if (pend_q.mode == MODE_FREE) begin
        ph_low_n = 1'b0;
        el_n     = '0;
        pin_n    = 1'b1;
      end else begin
        pin_n = in_win(tod_ns_nxt, pend_q.low, pend_q.high);
      end
    end else begin
      case (act_q.mode)
        MODE_FREE: begin
          if (!ph_low_q) begin
            if (el_sum >= {1'b0, act_q.high}) begin
              el_rem   = el_sum - {1'b0, act_q.high};
              ph_low_n = 1'b1;
              el_n     = el_rem[PER_DW-1:0];
              pin_n    = 1'b0;
            end else begin
              el_n  = el_sum[PER_DW-1:0];
              pin_n = 1'b1;
            end
          end else begin
            if (end_low) begin
              el_rem   = el_sum - {1'b0, act_q.low};
              ph_low_n = 1'b0;
              el_n     = el_rem[PER_DW-1:0];
              pin_n    = 1'b1;
            end else begin
              el_n  = el_sum[PER_DW-1:0];
              pin_n = 1'b0;
            end
          end
        end
        MODE_SYNC: pin_n = in_win(tod_ns_nxt, act_q.low, act_q.high);
        default:   pin_n = 1'b0;
      endcase
    end
    if (commit) begin
      pend_n     = cmd;
      pend_vld_n = 1'b1;
    end
    if (stop) begin
      act_n.mode = MODE_IDLE;
      pend_vld_n = 1'b0;
      pin_n      = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= '{mode: MODE_IDLE, high: '0, low: '0};
      pend_q     <= '{mode: MODE_IDLE, high: '0, low: '0};
      pend_vld_q <= 1'b0;
      ph_low_q   <= 1'b0;
      el_q       <= '0;
      pin_q      <= 1'b0;
    end else begin
      act_q      <= act_n;
      pend_q     <= pend_n;
      pend_vld_q <= pend_vld_n;
      ph_low_q   <= ph_low_n;
      el_q       <= el_n;
      pin_q      <= pin_n;
    end
  end

  // R12
  idle_pin_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act_q.mode == MODE_IDLE) |-> !pin_q);

  // R12
  stop_low_chk: assert property (@(posedge clk) disable iff (rst)
    stop |=> !pin_q);

  // R11
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_vld_q && (pend_q.mode == MODE_SYNC) && !tod_wrap && !stop) |=> pend_vld_q);

endmodule

// File: rtl/ptp_pin_wavegen.sv
module ptp_pin_wavegen
  import ptpw_pkg::*;
#(
  parameter int NS_STEP   = 8,
  parameter int SEC_NS    = 1000000000,
  parameter int TOD_NS_W  = 30,
  parameter int SEC_W     = 48,
  parameter int MIN_PER   = 6,
  parameter int MAX_PER   = 32'h3FFFFFFF,
  parameter int DEF_WIDTH = 1000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [31:0]         wr_data,
  output logic                pin_out,
  output logic                cfg_err,
  output logic [SEC_W-1:0]    tod_sec,
  output logic [TOD_NS_W-1:0] tod_ns
);

  logic [TOD_NS_W-1:0] ns_nxt;
  logic wrap, commit, stop;
  wave_cfg_t cmd;

  ptpw_tod #(
    .NS_STEP(NS_STEP), .SEC_NS(SEC_NS), .TOD_NS_W(TOD_NS_W), .SEC_W(SEC_W)
  ) u_tod (
    .clk(clk), .rst(rst), .ns_q(tod_ns), .sec_q(tod_sec),
    .ns_nxt(ns_nxt), .wrap(wrap)
  );

  ptpw_cfg #(
    .SEC_NS(SEC_NS), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER), .DEF_WIDTH(DEF_WIDTH)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit_q(commit), .cmd_q(cmd), .stop_q(stop), .err_q(cfg_err)
  );

  ptpw_engine #(
    .NS_STEP(NS_STEP), .TOD_NS_W(TOD_NS_W)
  ) u_eng (
    .clk(clk), .rst(rst), .commit(commit), .cmd(cmd), .stop(stop),
    .tod_ns_nxt(ns_nxt), .tod_wrap(wrap), .pin_q(pin_out)
  );

endmodule

// File: tb/ptp_pin_wavegen_tb.sv
module ptp_pin_wavegen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;
  localparam int SECN = 2000;
  localparam int LIM  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic pin_out, cfg_err;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_pin_wavegen #(.NS_STEP(STEP), .SEC_NS(SECN)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pin_out(pin_out), .cfg_err(cfg_err), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  task automatic chk(input string tag, input longint actual, input longint expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_level(input logic lvl);
    for (int i = 0; i < LIM && pin_out != lvl; i++) @(negedge clk);
  endtask

  task automatic measure(input logic lvl, output int n);
    n = 0;
    while (pin_out == lvl && n < LIM) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pin in reset", pin_out, 0);
    chk("R1 err in reset", cfg_err, 0);
    chk("R1 tod in reset", {tod_sec, 18'd0} | tod_ns, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 pin after reset", pin_out, 0);
  endtask

  task automatic t_tod();
    logic [29:0] prev;
    do_reset();
    @(negedge clk);
    prev = tod_ns;
    @(negedge clk);
    chk("R2 step", tod_ns - prev, STEP);
    for (int i = 0; i < LIM && tod_sec == 0; i++) begin
      prev = tod_ns;
      @(negedge clk);
    end
    chk("R2 sec incr", tod_sec, 1);
    chk("R2 ns wrap", tod_ns, 0);
    chk("R2 ns before wrap", prev, SECN - STEP);
  endtask

  task automatic t_free();
    int n;
    do_reset();
    wr(2'd0, 32'd40);
    wr(2'd1, 32'd60);
    repeat (4) @(negedge clk);
    chk("R3 period writes alone leave pin low", pin_out, 0);
    wr(2'd2, 32'h1);
    wait_level(1'b1);
    measure(1'b1, n); chk("R4 high length", n, 10);
    measure(1'b0, n); chk("R4 low length", n, 15);
    measure(1'b1, n); chk("R4 second high", n, 10);
    chk("R5 accepted err clear", cfg_err, 0);
  endtask

  task automatic t_boundary_update();
    int n;
    wait_level(1'b0);
    wait_level(1'b1);
    wr(2'd0, 32'd80);
    wr(2'd1, 32'd40);
    wr(2'd2, 32'h1);
    wait_level(1'b0);
    measure(1'b0, n); chk("R11 old low completes", n, 15);
    measure(1'b1, n); chk("R11 new high", n, 20);
    measure(1'b0, n); chk("R11 new low", n, 10);
  endtask

  task automatic t_reject();
    int n;
    wr(2'd0, 32'd6);
    wr(2'd2, 32'h1);
    repeat (2) @(negedge clk);
    chk("R5 period 6 rejected", cfg_err, 1);
    wait_level(1'b0);
    wait_level(1'b1);
    measure(1'b1, n); chk("R10 old high kept", n, 20);
    measure(1'b0, n); chk("R10 old low kept", n, 10);
    wr(2'd0, 32'd40);
    wr(2'd1, 32'h40000000);
    wr(2'd2, 32'h1);
    wr(2'd2, 32'h2);
    repeat (2) @(negedge clk);
    chk("R10 err sticky", cfg_err, 1);
    wait_level(1'b0);
    wait_level(1'b1);
    measure(1'b1, n); chk("R8 reserved action ignored high", n, 20);
    measure(1'b0, n); chk("R5 oversize low ignored", n, 10);
  endtask

  task automatic t_limits();
    do_reset();
    wr(2'd0, 32'd7);
    wr(2'd1, 32'h3FFFFFFF);
    wr(2'd2, 32'h1);
    repeat (3) @(negedge clk);
    chk("R5 7 and max accepted", cfg_err, 0);
    wr(2'd0, 32'h3FFFFFFF);
    wr(2'd1, 32'd7);
    wr(2'd2, 32'h1);
    repeat (3) @(negedge clk);
    chk("R5 max and 7 accepted", cfg_err, 0);
  endtask

  task automatic t_disable();
    int highs;
    do_reset();
    wr(2'd0, 32'd40);
    wr(2'd1, 32'd60);
    wr(2'd2, 32'h1);
    wait_level(1'b1);
    @(negedge clk);
    wr(2'd2, 32'h9);
    @(negedge clk);
    chk("R12 pin low after disable", pin_out, 0);
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (pin_out) highs++;
    end
    chk("R12 pin stays low", highs, 0);
    wr(2'd2, 32'h1);
    wait_level(1'b1);
    wr(2'd2, 32'h0);
    @(negedge clk);
    chk("R12 action 0 stops", pin_out, 0);
  endtask

  task automatic sync_watch(input string tag, input int lo, input int hi);
    int bad, early;
    bad = 0; early = 0;
    for (int i = 0; i < LIM && tod_sec < 3; i++) begin
      if (tod_sec == 0) begin
        if (pin_out) early++;
      end else begin
        if (pin_out != ((tod_ns >= lo) && (tod_ns - lo < hi))) bad++;
      end
      @(negedge clk);
    end
    chk({tag, " R11 waits for rollover"}, early, 0);
    chk({tag, " window mismatches"}, bad, 0);
  endtask

  task automatic t_sync_default();
    do_reset();
    wr(2'd2, 32'h5);
    sync_watch("R9 default width", 0, 1000);
  endtask

  task automatic t_sync_phase();
    do_reset();
    wr(2'd1, 32'd400);
    wr(2'd0, 32'd200);
    wr(2'd2, 32'h5);
    sync_watch("R6 phase", 400, 200);
  endtask

  task automatic t_sync_clip();
    do_reset();
    wr(2'd1, 32'd1800);
    wr(2'd0, 32'd1000);
    wr(2'd2, 32'h5);
    sync_watch("R7 clip", 1800, 200);
    for (int i = 0; i < LIM && tod_ns != 0; i++) @(negedge clk);
    chk("R7 low at rollover", pin_out, 0);
  endtask

  task automatic t_sync_reject();
    int highs;
    do_reset();
    wr(2'd1, 32'd2000);
    wr(2'd2, 32'h5);
    repeat (2) @(negedge clk);
    chk("R8 phase at second rejected", cfg_err, 1);
    highs = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (pin_out) highs++;
    end
    chk("R10 idle kept after reject", highs, 0);
    do_reset();
    wr(2'd0, 32'd0);
    wr(2'd2, 32'h5);
    repeat (2) @(negedge clk);
    chk("R8 zero width rejected", cfg_err, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_tod();
    t_free();
    t_boundary_update();
    t_reject();
    t_limits();
    t_disable();
    t_sync_default();
    t_sync_phase();
    t_sync_clip();
    t_sync_reject();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule